// File: doc/BRIEF.md
# Teletext Page Request Matcher

This block stores the page a host wants to capture and checks every received teletext page header against it. The host first loads a start-column pointer. It then writes request columns one after another, and the pointer steps forward by one after each write. Each request column carries a digit and a care flag. A single comparator therefore covers plain page selection (magazine, tens, units) and timed-page selection, where the hours and minutes digits are also compared. A hold bit in the magazine column stops any capture while the host is still editing the request.

When an accepted header arrives, the block latches its fields into a ten-column received-page status record. It also drives two flags: a found flag (active low) and a looking-for flag. A small state machine tracks the search. It has three states: `ST_IDLE` (no request written since reset), `ST_SEEK` (request written, page not yet captured) and `ST_FOUND` (page captured). Its transitions are:
- IDLE to SEEK on any request write.
- SEEK to FOUND on an accepted header.
- FOUND to FOUND on an accepted header, which refreshes the record.
- SEEK or FOUND to SEEK on any request write.

Top module: `page_req_match`

## Requirements
- R1: After reset, found_n is 1 and looking is 0. status_rec is all zero except bit 4 of column 8 (found_n), and every request column holds 0, so the hold bit is 0 (held).
- R2: A cycle with ptr_load high loads the 3-bit column pointer from ptr_value. A req_wr cycle without ptr_load writes req_data into the column the pointer selects, then advances the pointer by one, wrapping from 7 to 0. When ptr_load and req_wr are high in the same cycle, the write is ignored.
- R3: An accepted request write sets looking to 1 and found_n to 1 from the next cycle. A header presented in that same cycle is not captured.
- R4: Request column layout: column 0 is magazine (bits 2:0), column 1 page tens, column 2 page units, column 3 hours tens (bits 1:0), column 4 hours units, column 5 minutes tens (bits 2:0), column 6 minutes units. Bit 4 of each column is its care flag. A digit whose care flag is 0 is ignored. A digit whose care flag is 1 must equal the header field.
- R5: A header with the Hamming error flag set on a cared digit does not match. An error on a digit that is not cared about does not prevent a match. The error flags map as follows: flag 0 page units, 1 page tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens.
- R6: While bit 3 of request column 0 (hold enable) is 0, a matching header changes neither the flags nor the status record.
- R7: A matching header with hold enable at 1, presented while a request is active, gives found_n 0 and looking 0 from the next cycle and latches the record. Later matching headers refresh it.
- R8: Columns 0 to 7 of the record (column k at status_rec[8k+7:8k]) hold page units, page tens, minutes units, minutes tens, hours units, hours tens, C7..C10 and C11..C14 in bits 3:0 (C7 and C11 in bit 0), with error flag k in bit 4. Column 3 bit 3 carries C4. Column 5 bits 2 and 3 carry C5 and C6. hdr_ctrl bit i carries control bit C(i+4).
- R9: Column 8 holds the captured magazine in bits 2:0 and found_n in bit 4. Column 9 holds looking in bit 5.
- R10: Bits 7:5 of every record column are 0, except bit 5 of column 9.
- R11: A header magazine value of 0 is compared as 0, with no translation.
- R12: Request column 7 is stored but never takes part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_load | input | 1 | Load the column pointer |
| ptr_value | input | 3 | Start column for following writes |
| req_wr | input | 1 | Write one request column |
| req_data | input | 5 | Request column value (bit 4 care) |
| hdr_valid | input | 1 | Decoded header fields are valid this cycle |
| hdr_mag | input | 3 | Header magazine |
| hdr_pt | input | 4 | Header page tens |
| hdr_pu | input | 4 | Header page units |
| hdr_ht | input | 2 | Header hours tens |
| hdr_hu | input | 4 | Header hours units |
| hdr_mt | input | 3 | Header minutes tens |
| hdr_mu | input | 4 | Header minutes units |
| hdr_ctrl | input | 11 | Control bits C4..C14 (bit 0 is C4) |
| hdr_herr | input | 8 | Per-byte Hamming error flags |
| found_n | output | 1 | Low once the requested page is captured |
| looking | output | 1 | High while the request is being sought |
| status_rec | output | 80 | Ten 8-bit received-page status columns |

## Verification
The embedded assertions check on every cycle that:
- the pointer loads and steps with wrap-around;
- every accepted write lands in the addressed column and forces the seeking flags;
- a captured header clears both flags;
- the record moves only on a capture;
- nothing moves while hold is low;
- the reserved record bits stay zero.

Only the bench scenarios can show that the masked comparison picks the right headers: care flags versus values, errors on cared versus ignored digits, a magazine of 0, the spare column 7, and timed-page selection. The same holds for the exact placement of control and error bits in the record. The bench reference model follows the request columns and the search state independently and compares all outputs every cycle.

// File: rtl/pgreq_pkg.sv
package pgreq_pkg;

    localparam int REQ_COLS  = 8;
    localparam int REQ_W     = 5;
    localparam int NDIG      = 7;
    localparam int STAT_COLS = 10;
    localparam int STAT_W    = 8;
    localparam int CTRL_BITS = 11;
    localparam int HERR_BITS = 8;

    localparam int CARE_BIT  = 4;
    localparam int HOLD_BIT  = 3;
    localparam int COL_MAG   = 0;

    // Significant bits of each request digit, in request column order
    localparam logic [3:0] DIG_MASK [NDIG] = '{4'h7, 4'hF, 4'hF, 4'h3, 4'hF, 4'h7, 4'hF};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEEK  = 2'd1,
        ST_FOUND = 2'd2
    } seek_state_e;

    typedef struct packed {
        logic [2:0]           mag;
        logic [3:0]           pt;
        logic [3:0]           pu;
        logic [1:0]           ht;
        logic [3:0]           hu;
        logic [2:0]           mt;
        logic [3:0]           mu;
        logic [CTRL_BITS-1:0] ctrl;
        logic [HERR_BITS-1:0] herr;
    } hdr_t;

endpackage

// File: rtl/pgreq_store.sv
module pgreq_store #(
    parameter int COLS = 8,
    parameter int W    = 5,
    localparam int PW  = $clog2(COLS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ptr_load,
    input  logic [PW-1:0]         ptr_value,
    input  logic                  wr_en,
    input  logic [W-1:0]          wr_data,
    output logic [COLS-1:0][W-1:0] req_cols,
    output logic                  wr_done
);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_inc;
    logic [W-1:0]  col_q [COLS];

    // pointer load wins over a simultaneous write
    assign wr_done = wr_en && !ptr_load;
    assign ptr_inc = (ptr_q == PW'(COLS - 1)) ? '0 : ptr_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= ptr_value;
        end else if (wr_done) begin
            ptr_q <= ptr_inc;
        end
    end

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    col_q[c] <= '0;
                end else if (wr_done && ptr_q == PW'(c)) begin
                    col_q[c] <= wr_data;
                end
            end
            assign req_cols[c] = col_q[c];
        end
    endgenerate

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> ptr_q == $past(ptr_value));

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> ptr_q == (($past(ptr_q) == PW'(COLS - 1)) ? '0 : $past(ptr_q) + 1'b1));

    // R2
    col_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> col_q[$past(ptr_q)] == $past(wr_data));

endmodule

// File: rtl/pgreq_compare.sv
module pgreq_compare
    import pgreq_pkg::*;
#(
    parameter int COLS = 8,
    parameter int W    = 5
) (
    input  logic [COLS-1:0][W-1:0] req_cols,
    input  logic [2:0]             h_mag,
    input  logic [3:0]             h_pt,
    input  logic [3:0]             h_pu,
    input  logic [1:0]             h_ht,
    input  logic [3:0]             h_hu,
    input  logic [2:0]             h_mt,
    input  logic [3:0]             h_mu,
    input  logic [5:0]             h_err,
    output logic                   hit,
    output logic                   hold_open
);

    logic [3:0]      got  [NDIG];
    logic            gerr [NDIG];
    logic [COLS-1:0] dig_ok;

    // Header digits re-ordered into request column order
    always_comb begin
        got[0] = {1'b0, h_mag};  gerr[0] = 1'b0;
        got[1] = h_pt;           gerr[1] = h_err[1];
        got[2] = h_pu;           gerr[2] = h_err[0];
        got[3] = {2'b00, h_ht};  gerr[3] = h_err[5];
        got[4] = h_hu;           gerr[4] = h_err[4];
        got[5] = {1'b0, h_mt};   gerr[5] = h_err[3];
        got[6] = h_mu;           gerr[6] = h_err[2];
    end

    generate
        for (genvar d = 0; d < COLS; d++) begin : g_dig
            if (d < NDIG) begin : g_used
                logic care;
                logic same;
                assign care      = req_cols[d][CARE_BIT];
                assign same      = ((req_cols[d][3:0] ^ got[d]) & DIG_MASK[d]) == 4'h0;
                assign dig_ok[d] = !care || (same && !gerr[d]);
            end else begin : g_spare
                logic [W-1:0] spare_unused;
                assign spare_unused = req_cols[d];
                assign dig_ok[d]    = 1'b1;
            end
        end
    endgenerate

    assign hit       = &dig_ok;
    assign hold_open = req_cols[COL_MAG][HOLD_BIT];

endmodule

// File: rtl/pgreq_status.sv
module pgreq_status
    import pgreq_pkg::*;
#(
    parameter int NCOL = STAT_COLS,
    localparam int RW  = NCOL * STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  hdr_t          hdr,
    input  logic          found_n,
    input  logic          looking,
    output logic [RW-1:0] rec
);

    hdr_t       cap_q;
    logic [7:0] col [NCOL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (capture) begin
            cap_q <= hdr;
        end
    end

    always_comb begin
        for (int k = 0; k < NCOL; k++) col[k] = 8'h00;
        col[0] = {3'b000, cap_q.herr[0], cap_q.pu};
        col[1] = {3'b000, cap_q.herr[1], cap_q.pt};
        col[2] = {3'b000, cap_q.herr[2], cap_q.mu};
        col[3] = {3'b000, cap_q.herr[3], cap_q.ctrl[0], cap_q.mt};
        col[4] = {3'b000, cap_q.herr[4], cap_q.hu};
        col[5] = {3'b000, cap_q.herr[5], cap_q.ctrl[2], cap_q.ctrl[1], cap_q.ht};
        col[6] = {3'b000, cap_q.herr[6], cap_q.ctrl[6:3]};
        col[7] = {3'b000, cap_q.herr[7], cap_q.ctrl[10:7]};
        col[8] = {3'b000, found_n, 1'b0, cap_q.mag};
        col[9] = {2'b00, looking, 5'b00000};
    end

    generate
        for (genvar k = 0; k < NCOL; k++) begin : g_pack
            assign rec[k*STAT_W +: STAT_W] = col[k];
        end
    endgenerate

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec[(NCOL-1)*STAT_W +: STAT_W] == {2'b00, looking, 5'b00000});

    // R6
    record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rec[8*STAT_W-1:0]));

endmodule

// File: rtl/page_req_match.sv
module page_req_match
    import pgreq_pkg::*;
#(
    parameter int REQ_NCOLS = REQ_COLS,
    localparam int PTR_W    = $clog2(REQ_NCOLS),
    localparam int REC_W    = STAT_COLS * STAT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ptr_load,
    input  logic [PTR_W-1:0]     ptr_value,
    input  logic                 req_wr,
    input  logic [REQ_W-1:0]     req_data,
    input  logic                 hdr_valid,
    input  logic [2:0]           hdr_mag,
    input  logic [3:0]           hdr_pt,
    input  logic [3:0]           hdr_pu,
    input  logic [1:0]           hdr_ht,
    input  logic [3:0]           hdr_hu,
    input  logic [2:0]           hdr_mt,
    input  logic [3:0]           hdr_mu,
    input  logic [CTRL_BITS-1:0] hdr_ctrl,
    input  logic [HERR_BITS-1:0] hdr_herr,
    output logic                 found_n,
    output logic                 looking,
    output logic [REC_W-1:0]     status_rec
);

    logic [REQ_NCOLS-1:0][REQ_W-1:0] req_cols;
    logic        wr_done;
    logic        hit;
    logic        hold_open;
    logic        accept;
    logic        capture;
    hdr_t        hdr;
    seek_state_e state_q;
    seek_state_e state_d;

    assign hdr = '{mag: hdr_mag, pt: hdr_pt, pu: hdr_pu, ht: hdr_ht, hu: hdr_hu,
                   mt: hdr_mt, mu: hdr_mu, ctrl: hdr_ctrl, herr: hdr_herr};

    pgreq_store #(
        .COLS (REQ_NCOLS),
        .W    (REQ_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_load  (ptr_load),
        .ptr_value (ptr_value),
        .wr_en     (req_wr),
        .wr_data   (req_data),
        .req_cols  (req_cols),
        .wr_done   (wr_done)
    );

    pgreq_compare #(
        .COLS (REQ_NCOLS),
        .W    (REQ_W)
    ) u_cmp (
        .req_cols  (req_cols),
        .h_mag     (hdr_mag),
        .h_pt      (hdr_pt),
        .h_pu      (hdr_pu),
        .h_ht      (hdr_ht),
        .h_hu      (hdr_hu),
        .h_mt      (hdr_mt),
        .h_mu      (hdr_mu),
        .h_err     (hdr_herr[5:0]),
        .hit       (hit),
        .hold_open (hold_open)
    );

    // a header counts only when it matches, hold is open and no write competes
    assign accept  = hdr_valid && hit && hold_open && !wr_done;
    assign capture = accept && (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_done) state_d = ST_SEEK;
            ST_SEEK:  if (wr_done) state_d = ST_SEEK;
                      else if (accept) state_d = ST_FOUND;
            ST_FOUND: if (wr_done) state_d = ST_SEEK;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        found_n = (state_q != ST_FOUND);
        looking = (state_q == ST_SEEK);
    end

    pgreq_status #(
        .NCOL (STAT_COLS)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .hdr     (hdr),
        .found_n (found_n),
        .looking (looking),
        .rec     (status_rec)
    );

    // R3
    write_seeks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> looking && found_n);

    // R7
    capture_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !found_n && !looking);

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && !hold_open && !wr_done |=> $stable(status_rec) && $stable(found_n));

endmodule

// File: tb/page_req_match_test.sv
`timescale 1ns/1ps
module page_req_match_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_load = 1'b0;
    logic [2:0]  ptr_value = '0;
    logic        req_wr = 1'b0;
    logic [4:0]  req_data = '0;
    logic        hdr_valid = 1'b0;
    logic [2:0]  hdr_mag = '0;
    logic [3:0]  hdr_pt = '0;
    logic [3:0]  hdr_pu = '0;
    logic [1:0]  hdr_ht = '0;
    logic [3:0]  hdr_hu = '0;
    logic [2:0]  hdr_mt = '0;
    logic [3:0]  hdr_mu = '0;
    logic [10:0] hdr_ctrl = '0;
    logic [7:0]  hdr_herr = '0;
    logic        found_n;
    logic        looking;
    logic [79:0] status_rec;

    int checks = 0;
    int fails = 0;
    bit checking = 0;

    always #2 clk = ~clk;

    page_req_match uut (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_value(ptr_value),
        .req_wr(req_wr), .req_data(req_data), .hdr_valid(hdr_valid),
        .hdr_mag(hdr_mag), .hdr_pt(hdr_pt), .hdr_pu(hdr_pu), .hdr_ht(hdr_ht),
        .hdr_hu(hdr_hu), .hdr_mt(hdr_mt), .hdr_mu(hdr_mu), .hdr_ctrl(hdr_ctrl),
        .hdr_herr(hdr_herr), .found_n(found_n), .looking(looking),
        .status_rec(status_rec)
    );

    // ---------------- reference model ----------------
    logic [4:0] m_req [8];
    int         m_ptr = 0;
    int         m_state = 0;   // 0 idle, 1 seeking, 2 found
    logic [2:0] c_mag = '0;
    logic [3:0] c_pt = '0, c_pu = '0, c_hu = '0, c_mu = '0;
    logic [1:0] c_ht = '0;
    logic [2:0] c_mt = '0;
    logic [10:0] c_ctrl = '0;
    logic [7:0] c_herr = '0;

    initial for (int i = 0; i < 8; i++) m_req[i] = '0;

    function automatic bit ref_match();
        bit ok = 1;
        if (m_req[0][4] && m_req[0][2:0] != hdr_mag) ok = 0;
        if (m_req[1][4] && (m_req[1][3:0] != hdr_pt || hdr_herr[1])) ok = 0;
        if (m_req[2][4] && (m_req[2][3:0] != hdr_pu || hdr_herr[0])) ok = 0;
        if (m_req[3][4] && (m_req[3][1:0] != hdr_ht || hdr_herr[5])) ok = 0;
        if (m_req[4][4] && (m_req[4][3:0] != hdr_hu || hdr_herr[4])) ok = 0;
        if (m_req[5][4] && (m_req[5][2:0] != hdr_mt || hdr_herr[3])) ok = 0;
        if (m_req[6][4] && (m_req[6][3:0] != hdr_mu || hdr_herr[2])) ok = 0;
        return ok;
    endfunction

    function automatic logic [7:0] exp_col(int k);
        logic [7:0] v = 8'h00;
        case (k)
            0: v = {3'b0, c_herr[0], c_pu};
            1: v = {3'b0, c_herr[1], c_pt};
            2: v = {3'b0, c_herr[2], c_mu};
            3: v = {3'b0, c_herr[3], c_ctrl[0], c_mt};
            4: v = {3'b0, c_herr[4], c_hu};
            5: v = {3'b0, c_herr[5], c_ctrl[2], c_ctrl[1], c_ht};
            6: v = {3'b0, c_herr[6], c_ctrl[6:3]};
            7: v = {3'b0, c_herr[7], c_ctrl[10:7]};
            8: v = {3'b0, (m_state != 2), 1'b0, c_mag};
            default: v = {2'b0, (m_state == 1), 5'b0};
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_req[i] = '0;
            m_ptr = 0;
            m_state = 0;
            {c_mag, c_pt, c_pu, c_ht, c_hu, c_mt, c_mu, c_ctrl, c_herr} = '0;
        end else begin
            bit hit;
            hit = ref_match();
            if (req_wr && !ptr_load) begin
                m_state = 1;
            end else if (hdr_valid && m_state != 0 && hit && m_req[0][3]) begin
                m_state = 2;
                c_mag = hdr_mag; c_pt = hdr_pt; c_pu = hdr_pu; c_ht = hdr_ht;
                c_hu = hdr_hu; c_mt = hdr_mt; c_mu = hdr_mu;
                c_ctrl = hdr_ctrl; c_herr = hdr_herr;
            end
            if (ptr_load) begin
                m_ptr = int'(ptr_value);
            end else if (req_wr) begin
                m_req[m_ptr] = req_data;
                m_ptr = (m_ptr + 1) % 8;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            chk("R7 found_n", 32'(found_n), 32'(m_state != 2));
            chk("R3 looking", 32'(looking), 32'(m_state == 1));
            for (int k = 0; k < 8; k++) chk("R8 column", 32'(status_rec[k*8 +: 8]), 32'(exp_col(k)));
            chk("R9 column 8", 32'(status_rec[71:64]), 32'(exp_col(8)));
            chk("R9 column 9", 32'(status_rec[79:72]), 32'(exp_col(9)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic load_ptr(int p);
        ptr_load = 1'b1; ptr_value = 3'(p);
        cyc();
        ptr_load = 1'b0;
    endtask

    task automatic write_col(logic [4:0] d);
        req_wr = 1'b1; req_data = d;
        cyc();
        req_wr = 1'b0;
    endtask

    task automatic set_hdr(int mag, int pt, int pu, int ht, int hu, int mt, int mu,
                           logic [10:0] ctrl, logic [7:0] herr);
        hdr_mag = 3'(mag); hdr_pt = 4'(pt); hdr_pu = 4'(pu); hdr_ht = 2'(ht);
        hdr_hu = 4'(hu); hdr_mt = 3'(mt); hdr_mu = 4'(mu);
        hdr_ctrl = ctrl; hdr_herr = herr;
    endtask

    task automatic send_hdr(int mag, int pt, int pu, int ht, int hu, int mt, int mu,
                            logic [10:0] ctrl, logic [7:0] herr);
        set_hdr(mag, pt, pu, ht, hu, mt, mu, ctrl, herr);
        hdr_valid = 1'b1;
        cyc();
        hdr_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R1..R12 not completed) actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [63:0] snap;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        checking = 1;

        // R1: reset state
        chk("R1 found_n", 32'(found_n), 32'd1);
        chk("R1 looking", 32'(looking), 32'd0);
        chk("R1 record low", 32'(status_rec[31:0]), 32'h0);
        chk("R1 record col8/9", 32'(status_rec[79:64]), 32'h0010);

        // plain page request: mag 3 held open, page 25, no time care
        load_ptr(0);
        write_col(5'h1B); write_col(5'h12); write_col(5'h15);
        write_col(5'h00); write_col(5'h00); write_col(5'h00); write_col(5'h00);
        chk("R3 looking after write", 32'(looking), 32'd1);
        chk("R3 found_n after write", 32'(found_n), 32'd1);

        // R4: wrong magazine rejected
        send_hdr(4, 2, 5, 1, 9, 4, 7, 11'h5A5, 8'h80);
        chk("R4 magazine mismatch", 32'(looking), 32'd1);

        // R7/R8/R9: matching header captured
        send_hdr(3, 2, 5, 1, 9, 4, 7, 11'h5A5, 8'h80);
        chk("R7 found", 32'(found_n), 32'd0);
        chk("R7 not looking", 32'(looking), 32'd0);
        chk("R8 col0", 32'(status_rec[7:0]), 32'h05);
        chk("R8 col3 C4", 32'(status_rec[31:24]), 32'h0C);
        chk("R8 col5 C5 C6", 32'(status_rec[47:40]), 32'h09);
        chk("R8 col6", 32'(status_rec[55:48]), 32'h04);
        chk("R8 col7 err", 32'(status_rec[63:56]), 32'h1B);
        chk("R9 col8", 32'(status_rec[71:64]), 32'h03);
        chk("R9 col9", 32'(status_rec[79:72]), 32'h00);

        // R7: refresh by later match (uncared minutes differ)
        send_hdr(3, 2, 5, 1, 9, 4, 3, 11'h000, 8'h00);
        chk("R7 refresh col2", 32'(status_rec[23:16]), 32'h03);

        // R5: error on cared page tens blocks match
        load_ptr(1); write_col(5'h12);
        send_hdr(3, 2, 5, 0, 0, 0, 0, 11'h000, 8'h02);
        chk("R5 cared error", 32'(looking), 32'd1);
        // R5: error on uncared hours units is harmless
        send_hdr(3, 2, 5, 0, 6, 0, 0, 11'h000, 8'h10);
        chk("R5 uncared error", 32'(found_n), 32'd0);
        chk("R5 col4 err bit", 32'(status_rec[39:32]), 32'h16);

        // R4: timed page selection with all time digits cared
        load_ptr(3);
        write_col(5'h11); write_col(5'h12); write_col(5'h13); write_col(5'h14);
        send_hdr(3, 2, 5, 1, 2, 3, 5, 11'h000, 8'h00);
        chk("R4 timed mismatch", 32'(looking), 32'd1);
        send_hdr(3, 2, 5, 1, 2, 3, 4, 11'h000, 8'h00);
        chk("R4 timed match", 32'(found_n), 32'd0);

        // R6: hold bit low freezes capture
        load_ptr(0); write_col(5'h13);
        snap = status_rec[63:0];
        send_hdr(3, 2, 5, 1, 2, 3, 4, 11'h7FF, 8'h00);
        chk("R6 still looking", 32'(looking), 32'd1);
        chk("R6 record low unchanged", status_rec[31:0], snap[31:0]);
        chk("R6 record high unchanged", status_rec[63:32], snap[63:32]);

        // R2/R12: pointer wraps 6 -> 7 -> 0, column 7 ignored
        load_ptr(6);
        write_col(5'h14); write_col(5'h1F); write_col(5'h1B);
        send_hdr(3, 2, 5, 1, 2, 3, 4, 11'h000, 8'h00);
        chk("R2 wrap match", 32'(found_n), 32'd0);
        chk("R12 spare column", 32'(looking), 32'd0);

        // R2: simultaneous load and write, write ignored
        ptr_load = 1'b1; ptr_value = 3'd0; req_wr = 1'b1; req_data = 5'h00;
        cyc();
        ptr_load = 1'b0; req_wr = 1'b0;
        chk("R2 write dropped", 32'(looking), 32'd0);
        send_hdr(3, 2, 5, 1, 2, 3, 4, 11'h000, 8'h00);
        chk("R2 column 0 kept", 32'(found_n), 32'd0);

        // R3: header alongside a write is not captured
        set_hdr(3, 2, 5, 1, 2, 3, 4, 11'h000, 8'h00);
        hdr_valid = 1'b1; req_wr = 1'b1; req_data = 5'h1B;
        cyc();
        hdr_valid = 1'b0; req_wr = 1'b0;
        chk("R3 same-cycle header", 32'(looking), 32'd1);

        // R11: magazine 0 compared as 0
        load_ptr(0); write_col(5'h18);
        send_hdr(0, 2, 5, 1, 2, 3, 4, 11'h000, 8'h00);
        chk("R11 mag 0 match", 32'(found_n), 32'd0);
        chk("R11 mag field", 32'(status_rec[71:64]), 32'h00);
        load_ptr(0); write_col(5'h18);
        send_hdr(7, 2, 5, 1, 2, 3, 4, 11'h000, 8'h00);
        chk("R11 mag 7 differs", 32'(looking), 32'd1);

        // R10: reserved bits
        for (int k = 0; k < 9; k++) chk("R10 reserved", 32'(status_rec[k*8+5 +: 3]), 32'd0);
        chk("R10 col9 others", 32'(status_rec[79:72] & 8'hDF), 32'd0);

        repeat (2) cyc();
        checking = 0;
        finish_run();
    end

endmodule